// File: doc/BRIEF.md
# Masked Vector Reduction and Scan Unit

This block takes one section of an integer vector (up to `SECTION` signed 32-bit elements delivered on a wide bus) and reduces it to scalar results. It supports three operations. A minimum reduction returns the smallest active element and where it sits. A sum reduction returns the total of the active elements. A priority scan locates the first set bit of a companion bit vector and also produces a mask that marks every element before that bit.

Only elements whose position is below the active count take part. The active count is the smaller of the requested vector length and the section size. When masking is enabled, a per-element mask bit also gates the two reductions. The caller pulses `start` with all operands valid. The unit then walks the section `LANES` elements per cycle and raises `done` for one cycle. The results stay on the outputs until the next operation completes.

Top module: `vrs_top`

## Requirements
- R1: With `op` = 2'b00 (minimum), `res_val` is the smallest active element, compared as signed, and `res_idx` is its position. On a tie the lowest position is reported.
- R2: With `op` = 2'b01 (sum), `res_val` starts from zero and adds every active element, wrapping modulo 2^32. The unused code 2'b11 behaves exactly like 2'b01. For both codes `res_idx` is 0.
- R3: With `op` = 2'b10 (priority scan), `res_idx` is the position of the lowest set bit of `bit_vec` among the active positions. If no active position has its bit set, `res_idx` equals the active count. For this operation `res_val` is 0.
- R4: For the priority scan, `res_prefix` bit i is 1 exactly when i is below `res_idx`. For the other operations `res_prefix` is all zero.
- R5: When `mask_en` is 1, elements whose `elem_mask` bit is 0 are ignored by the minimum and sum reductions. When `mask_en` is 0, `elem_mask` has no effect. The priority scan never uses the mask.
- R6: The active count is min(`vec_len`, `SECTION`). Elements and bits at or above the active count have no effect on any result.
- R7: With an active count of 0, the minimum returns 0x7FFFFFFF with index 0, the sum returns 0, and the priority scan returns position 0 with an empty prefix.
- R8: `start` is sampled on a clock edge while idle. `done` rises ceil(active count / `LANES`) + 1 edges later and lasts one cycle. A `start` seen while an operation is in progress is ignored.
- R9: After synchronous reset, `done`, `res_val`, `res_idx` and `res_prefix` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches an operation when the unit is idle |
| op | input | 2 | 00 minimum, 01 sum, 10 priority scan, 11 sum |
| vec_len | input | LENW | Requested number of elements |
| mask_en | input | 1 | Enables element masking for the reductions |
| elem_mask | input | SECTION | Per-element enable bits |
| vec_data | input | SECTION*W | Elements; element i occupies bits [i*W +: W] |
| bit_vec | input | SECTION | Bit vector searched by the priority scan |
| done | output | 1 | One-cycle completion pulse |
| res_val | output | W | Minimum value or sum |
| res_idx | output | IDXW | Minimum position or priority position |
| res_prefix | output | SECTION | Mask of the positions below the priority position |

## Verification
A broken merge between beats shows up as a wrong minimum or index, but only when the winner lies in a later group of `LANES` elements. The vectors therefore place minima and set bits in every beat position, including ties that span two beats. A wrong pointer or wrong stop condition in the sequencer changes the cycle on which `done` rises, so the bench counts edges from `start` for every operation. Stale accumulator state from a previous run appears in the very next result, because the bench runs operations back to back with different operands.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  typedef enum logic [1:0] {
    OP_MIN  = 2'b00,
    OP_SUM  = 2'b01,
    OP_PRIO = 2'b10,
    OP_RSV  = 2'b11
  } vrs_op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_FIN  = 2'd2
  } vrs_state_e;
endpackage

// File: rtl/vrs_min_beat.sv
module vrs_min_beat #(
  parameter int LANES = 4,
  parameter int W     = 32,
  parameter int IDXW  = 5
) (
  input  logic [LANES-1:0][W-1:0] vals,
  input  logic [LANES-1:0]        act,
  input  logic [IDXW-1:0]         base,
  output logic                    any,
  output logic [W-1:0]            minv,
  output logic [IDXW-1:0]         mini
);
  always_comb begin
    any  = 1'b0;
    minv = {1'b0, {(W-1){1'b1}}};
    mini = base;
    for (int j = 0; j < LANES; j++) begin
      // strict less-than keeps the lowest position on ties (R1)
      if (act[j] && (!any || ($signed(vals[j]) < $signed(minv)))) begin
        any  = 1'b1;
        minv = vals[j];
        mini = base + IDXW'(j);
      end
    end
  end
endmodule

// File: rtl/vrs_sum_beat.sv
module vrs_sum_beat #(
  parameter int LANES = 4,
  parameter int W     = 32
) (
  input  logic [LANES-1:0][W-1:0] vals,
  input  logic [LANES-1:0]        act,
  output logic [W-1:0]            sum
);
  always_comb begin
    sum = '0;
    for (int j = 0; j < LANES; j++)
      if (act[j]) sum = sum + vals[j];
  end
endmodule

// File: rtl/vrs_first_beat.sv
module vrs_first_beat #(
  parameter int LANES = 4,
  parameter int IDXW  = 5
) (
  input  logic [LANES-1:0] bits,
  input  logic [IDXW-1:0]  base,
  output logic             found,
  output logic [IDXW-1:0]  pos
);
  always_comb begin
    found = 1'b0;
    pos   = base;
    for (int j = 0; j < LANES; j++) begin
      if (!found && bits[j]) begin
        found = 1'b1;
        pos   = base + IDXW'(j);
      end
    end
  end
endmodule

// File: rtl/vrs_top.sv
module vrs_top
  import vrs_pkg::*;
#(
  parameter int SECTION = 16,
  parameter int LANES   = 4,
  parameter int W       = 32,
  parameter int LENW    = 16,
  localparam int IDXW   = $clog2(SECTION + LANES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [1:0]           op,
  input  logic [LENW-1:0]      vec_len,
  input  logic                 mask_en,
  input  logic [SECTION-1:0]   elem_mask,
  input  logic [SECTION*W-1:0] vec_data,
  input  logic [SECTION-1:0]   bit_vec,
  output logic                 done,
  output logic [W-1:0]         res_val,
  output logic [IDXW-1:0]      res_idx,
  output logic [SECTION-1:0]   res_prefix
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  vrs_state_e           st;
  vrs_op_e              op_q;
  logic [IDXW-1:0]      n_q, n_in, ptr;
  logic                 men_q;
  logic [SECTION-1:0]   msk_q, bit_q;
  logic [SECTION*W-1:0] dat_q;
  logic [W-1:0]         acc_min, acc_sum;
  logic [IDXW-1:0]      acc_idx, pos;
  logic                 acc_any, fnd;

  logic [W-1:0]              elem [SECTION];
  logic [LANES-1:0][W-1:0]   lane_val;
  logic [LANES-1:0]          lane_act, lane_bit;
  logic [IDXW-1:0]           lane_e [LANES];
  logic [SECTION-1:0]        pfx;

  logic            b_any, f_found;
  logic [W-1:0]    b_min, b_sum;
  logic [IDXW-1:0] b_idx, f_pos;

  // active count clamps the requested length to the section (R6)
  assign n_in = (vec_len > LENW'(SECTION)) ? IDXW'(SECTION) : vec_len[IDXW-1:0];

  for (genvar g = 0; g < SECTION; g++) begin : g_unpack
    assign elem[g] = dat_q[g*W +: W];
    assign pfx[g]  = (IDXW'(g) < pos);
  end

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      lane_e[j]   = ptr + IDXW'(j);
      lane_val[j] = '0;
      lane_act[j] = 1'b0;
      lane_bit[j] = 1'b0;
      for (int k = 0; k < SECTION; k++) begin
        if (lane_e[j] == IDXW'(k) && IDXW'(k) < n_q) begin
          lane_val[j] = elem[k];
          lane_act[j] = !men_q || msk_q[k];
          lane_bit[j] = bit_q[k];
        end
      end
    end
  end

  vrs_min_beat #(.LANES(LANES), .W(W), .IDXW(IDXW)) u_min (
    .vals(lane_val), .act(lane_act), .base(ptr),
    .any(b_any), .minv(b_min), .mini(b_idx));

  vrs_sum_beat #(.LANES(LANES), .W(W)) u_sum (
    .vals(lane_val), .act(lane_act), .sum(b_sum));

  vrs_first_beat #(.LANES(LANES), .IDXW(IDXW)) u_first (
    .bits(lane_bit), .base(ptr), .found(f_found), .pos(f_pos));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; done <= 1'b0;
      res_val <= '0; res_idx <= '0; res_prefix <= '0;
      op_q <= OP_MIN; n_q <= '0; ptr <= '0; men_q <= 1'b0;
      msk_q <= '0; bit_q <= '0; dat_q <= '0;
      acc_min <= MAXV; acc_sum <= '0; acc_idx <= '0; acc_any <= 1'b0;
      fnd <= 1'b0; pos <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op_q <= vrs_op_e'(op); n_q <= n_in; men_q <= mask_en;
          msk_q <= elem_mask; bit_q <= bit_vec; dat_q <= vec_data;
          ptr <= '0; acc_min <= MAXV; acc_sum <= '0; acc_idx <= '0;
          acc_any <= 1'b0; fnd <= 1'b0; pos <= n_in;
          st <= (n_in == '0) ? S_FIN : S_RUN;
        end
        S_RUN: begin
          if (b_any && (!acc_any || ($signed(b_min) < $signed(acc_min)))) begin
            acc_any <= 1'b1; acc_min <= b_min; acc_idx <= b_idx;
          end
          acc_sum <= acc_sum + b_sum;
          if (!fnd && f_found) begin
            fnd <= 1'b1; pos <= f_pos;
          end
          ptr <= ptr + IDXW'(LANES);
          if (ptr + IDXW'(LANES) >= n_q) st <= S_FIN;
        end
        S_FIN: begin
          done <= 1'b1;
          st   <= S_IDLE;
          case (op_q)
            OP_MIN:  begin res_val <= acc_min; res_idx <= acc_idx; res_prefix <= '0;  end
            OP_PRIO: begin res_val <= '0;      res_idx <= pos;     res_prefix <= pfx; end
            default: begin res_val <= acc_sum; res_idx <= '0;      res_prefix <= '0;  end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R8: operands are frozen while an operation is in flight
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE) |=> ($stable(op_q) && $stable(n_q)));
  // R4: the prefix has exactly as many ones as the reported position
  p_prefix_pop_r4: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_PRIO) |-> ($countones(res_prefix) == int'(res_idx)));
  // R3: the priority position never exceeds the active count
  p_prio_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_PRIO) |-> (res_idx <= n_q));
  // R6: a minimum index is always an active position
  p_min_idx_r6: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_MIN) |-> ((res_idx < n_q) || (res_idx == '0)));
  // R7: an empty sum is zero
  p_empty_sum_r7: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_SUM && n_q == '0) |-> (res_val == '0));
endmodule

// File: tb/tb_vrs_top.sv
module tb_vrs_top;
  localparam int SECTION = 16;
  localparam int LANES   = 4;
  localparam int W       = 32;
  localparam int LENW    = 16;
  localparam int IDXW    = $clog2(SECTION + LANES);

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] len;
    logic        men;
    logic [15:0] msk;
    logic [15:0] bv;
    logic [31:0] seed;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{2'b00, 16'd16,  1'b0, 16'h0000, 16'h0000, 32'd1,  4'd1},  // R1 full section
    '{2'b00, 16'd7,   1'b0, 16'h0000, 16'h0000, 32'd2,  4'd1},  // R1 partial
    '{2'b01, 16'd16,  1'b0, 16'h0000, 16'h0000, 32'd3,  4'd2},  // R2 wrapping sum
    '{2'b11, 16'd10,  1'b0, 16'h0000, 16'h0000, 32'd4,  4'd2},  // R2 spare code
    '{2'b10, 16'd16,  1'b0, 16'h0000, 16'h0100, 32'd0,  4'd3},  // R3 bit 8
    '{2'b10, 16'd11,  1'b0, 16'h0000, 16'h0000, 32'd0,  4'd3},  // R3 none set
    '{2'b10, 16'd16,  1'b0, 16'h0000, 16'h8001, 32'd0,  4'd4},  // R4 bit 0
    '{2'b10, 16'd13,  1'b0, 16'h0000, 16'h1000, 32'd0,  4'd4},  // R4 last beat
    '{2'b00, 16'd16,  1'b1, 16'hAAAA, 16'h0000, 32'd5,  4'd5},  // R5 masked min
    '{2'b01, 16'd16,  1'b0, 16'h0000, 16'h0000, 32'd6,  4'd5},  // R5 mask off
    '{2'b00, 16'd16,  1'b1, 16'h0000, 16'h0000, 32'd8,  4'd5},  // R5 all masked
    '{2'b10, 16'd16,  1'b1, 16'h0000, 16'h0040, 32'd0,  4'd5},  // R5 scan ignores mask
    '{2'b01, 16'd100, 1'b0, 16'h0000, 16'h0000, 32'd7,  4'd6},  // R6 clamp
    '{2'b10, 16'd3,   1'b0, 16'h0000, 16'h0010, 32'd0,  4'd6},  // R6 bit beyond count
    '{2'b00, 16'd0,   1'b0, 16'h0000, 16'h0000, 32'd9,  4'd7}   // R7 empty min
  };

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 start = 1'b0;
  logic [1:0]           op = '0;
  logic [LENW-1:0]      vec_len = '0;
  logic                 mask_en = 1'b0;
  logic [SECTION-1:0]   elem_mask = '0;
  logic [SECTION*W-1:0] vec_data = '0;
  logic [SECTION-1:0]   bit_vec = '0;
  logic                 done;
  logic [W-1:0]         res_val;
  logic [IDXW-1:0]      res_idx;
  logic [SECTION-1:0]   res_prefix;

  int n_checks = 0;
  int n_fail   = 0;
  logic [W-1:0] din [SECTION];

  vrs_top #(.SECTION(SECTION), .LANES(LANES), .W(W), .LENW(LENW)) dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .vec_len(vec_len),
    .mask_en(mask_en), .elem_mask(elem_mask), .vec_data(vec_data),
    .bit_vec(bit_vec), .done(done), .res_val(res_val), .res_idx(res_idx),
    .res_prefix(res_prefix));

  always #2 clk = ~clk;

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] gen(input logic [31:0] seed, input int i);
    logic [31:0] x;
    x = seed * 32'h9E3779B1 + 32'(i) * 32'h85EBCA6B;
    return x ^ (x >> 13);
  endfunction

  task automatic run_case(input logic [1:0] o, input logic [15:0] l, input logic me,
                          input logic [15:0] m, input logic [15:0] b, input string tag,
                          input int hold_start);
    int n, cyc, exp_cyc;
    logic any;
    logic [W-1:0] e_val, best, s;
    logic [IDXW-1:0] e_idx;
    logic [SECTION-1:0] e_pfx;
    n = (l > 16'(SECTION)) ? SECTION : int'(l);
    best = 32'h7FFFFFFF; any = 1'b0; s = '0; e_idx = '0;
    for (int i = 0; i < n; i++) begin
      if (!me || m[i]) begin
        s = s + din[i];
        if (!any || $signed(din[i]) < $signed(best)) begin
          best = din[i]; e_idx = IDXW'(i); any = 1'b1;
        end
      end
    end
    e_pfx = '0;
    if (o == 2'b00) e_val = best;
    else if (o == 2'b10) begin
      e_val = '0; e_idx = IDXW'(n);
      for (int i = n - 1; i >= 0; i--) if (b[i]) e_idx = IDXW'(i);
      for (int i = 0; i < SECTION; i++) e_pfx[i] = (i < int'(e_idx));
    end else begin
      e_val = s; e_idx = '0;
    end
    exp_cyc = (n + LANES - 1) / LANES + 1;

    @(negedge clk);
    for (int i = 0; i < SECTION; i++) vec_data[i*W +: W] = din[i];
    op = o; vec_len = l; mask_en = me; elem_mask = m; bit_vec = b; start = 1'b1;
    @(posedge clk); #1;
    cyc = 0;
    if (hold_start != 0) begin
      op = 2'b01; vec_len = 16'd1;   // busy-time start with other operands (R8)
    end else start = 1'b0;
    while (!done && cyc < 100) begin
      @(posedge clk); #1; cyc++;
      if (cyc == 2) start = 1'b0;
    end
    check(cyc == exp_cyc, {tag, " R8 latency"}, 64'(cyc), 64'(exp_cyc));
    check(res_val == e_val, {tag, " value"}, 64'(res_val), 64'(e_val));
    check(res_idx == e_idx, {tag, " index"}, 64'(res_idx), 64'(e_idx));
    check(res_prefix == e_pfx, {tag, " prefix R4"}, 64'(res_prefix), 64'(e_pfx));
    @(posedge clk); #1;
    check(done == 1'b0, {tag, " R8 pulse"}, 64'(done), 64'd0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++; n_checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check(done == 1'b0, "R9 done", 64'(done), 64'd0);
    check(res_val == '0 && res_idx == '0 && res_prefix == '0, "R9 results",
          64'(res_val), 64'd0);
    @(negedge clk) rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < SECTION; i++) din[i] = gen(TBL[v].seed, i);
      run_case(TBL[v].op, TBL[v].len, TBL[v].men, TBL[v].msk, TBL[v].bv,
               $sformatf("R%0d vec%0d", TBL[v].req, v), 0);
    end

    // R1 tie: all equal, lowest position wins
    for (int i = 0; i < SECTION; i++) din[i] = 32'd5;
    run_case(2'b00, 16'd16, 1'b0, '0, '0, "R1 all equal", 0);
    // R1 tie across beats: minimum -9 at 3 and 9
    for (int i = 0; i < SECTION; i++) din[i] = 32'(i * 100);
    din[3] = -32'sd9; din[9] = -32'sd9; din[14] = -32'sd8;
    run_case(2'b00, 16'd16, 1'b0, '0, '0, "R1 split tie", 0);
    // R6: smaller value beyond active count is ignored
    din[5] = 32'h8000_0000;
    run_case(2'b00, 16'd4, 1'b0, '0, '0, "R6 min beyond count", 0);
    // R2 signed overflow wraps
    for (int i = 0; i < SECTION; i++) din[i] = '0;
    din[0] = 32'h7FFF_FFFF; din[6] = 32'd1;
    run_case(2'b01, 16'd16, 1'b0, '0, '0, "R2 overflow", 0);
    // R7 empty sum and scan
    run_case(2'b01, 16'd0, 1'b0, '0, '0, "R7 empty sum", 0);
    run_case(2'b10, 16'd0, 1'b0, '0, 16'hFFFF, "R7 empty scan", 0);
    // R8 start held during a busy operation is ignored
    for (int i = 0; i < SECTION; i++) din[i] = gen(32'd11, i);
    run_case(2'b00, 16'd16, 1'b0, '0, '0, "R8 busy start", 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule